// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps one load-linked reservation for a single processor and rules on every store-conditional that follows. A load-linked request records the line of its address, sets a link flag and starts a countdown. The load data itself comes back through the ordinary load path. A store-conditional is judged in the cycle it is offered. It succeeds only when the link flag is set, its address falls in the reserved line and the countdown is still nonzero. On success its write goes out at once on a valid/ready memory write port. Every store-conditional gets a status code one cycle after it is accepted: zero means success, and any nonzero value tells software to go back and retry the sequence.

Several events cancel the reservation. A read by another agent to the reserved line cancels it, and so does a DMA write or invalidate to that line. A taken interrupt cancels it whatever the address. Every accepted store-conditional, pass or fail, also consumes it. Addresses are compared per line: bits at and above `OFS_W` are compared, and the offset bits below are ignored. A successful store-conditional reaches memory in the cycle it is offered, so it costs no more cycles than a plain store.

The store-conditional request and the memory write port follow valid/ready rules. The CPU must hold `sc_valid`, `sc_addr` and `sc_data` steady until `sc_ready` is high at a clock edge. A store-conditional that will write is accepted only in the cycle the memory side is ready. A store-conditional that fails is accepted at once. Once `mem_wr_valid` has risen it stays high, with an unchanged address and data, until `mem_wr_ready` takes the write.

Top module: `llsc_monitor`

## Requirements
- R1: After a load-linked, a store-conditional to the same line, within the window and with no cancelling event, is accepted, drives `mem_wr_valid` in the same cycle with its own address and data, and returns status 0.
- R2: Line matching ignores the low `OFS_W` address bits: a store-conditional at another offset in the reserved line succeeds and writes to its own address.
- R3: With a load-linked accepted at edge t, a store-conditional accepted at edge t+k succeeds when 1 <= k <= `PRESET` and fails with status 3 (expired) when k > `PRESET`.
- R4: A snoop read to the reserved line cancels the reservation, so the next store-conditional fails with status 1. A snoop read to any other line has no effect.
- R5: A DMA write/invalidate to the reserved line cancels the reservation (status 1 next). A DMA access to another line has no effect.
- R6: A taken interrupt cancels the reservation whatever the address; the next store-conditional fails with status 1.
- R7: Every accepted store-conditional consumes the reservation, so a second one without a new load-linked fails with status 1.
- R8: A store-conditional to a line other than the reserved one fails with status 2 and does not write.
- R9: A load-linked in the same cycle as a cancelling event leaves a valid reservation. A new load-linked replaces the reserved line and restarts the countdown.
- R10: `resp_valid` is high for exactly the one cycle after each acceptance. The status codes are 0 success, 1 no reservation, 2 line mismatch and 3 expired. When several failures apply, 1 takes priority over 2, and 2 over 3.
- R11: A store-conditional that will write has `sc_ready` equal to `mem_wr_ready`. A failing one sees `sc_ready` high. A raised `mem_wr_valid` holds with a stable address and data until `mem_wr_ready`, even if a cancelling event arrives meanwhile.
- R12: After reset there is no reservation, `resp_valid` and `mem_wr_valid` are low, and a store-conditional fails with status 1.
- R13: A store-conditional is judged on the reservation held at the start of its cycle. A cancelling event in that same cycle does not change its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-linked request strobe |
| ll_addr | input | ADDR_W | Load-linked address |
| sc_valid | input | 1 | Store-conditional request valid |
| sc_ready | output | 1 | Store-conditional accepted this cycle |
| sc_addr | input | ADDR_W | Store-conditional address |
| sc_data | input | DATA_W | Store-conditional write data |
| resp_valid | output | 1 | Status valid, one cycle after acceptance |
| resp_code | output | 2 | Status: 0 ok, 1 no reservation, 2 mismatch, 3 expired |
| mem_wr_valid | output | 1 | Memory write valid |
| mem_wr_ready | input | 1 | Memory write ready |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| snoop_valid | input | 1 | Read by another agent |
| snoop_addr | input | ADDR_W | Address of that read |
| dma_valid | input | 1 | DMA write or invalidate |
| dma_addr | input | ADDR_W | DMA address |
| irq_taken | input | 1 | Interrupt-taken pulse |

## Verification
The properties assume two things about the inputs. The CPU never offers a load-linked and a store-conditional in the same cycle. It also keeps a stalled store-conditional's valid, address and data unchanged until acceptance. The write-hold property holds only under these conditions. The bench drives each request from a task that starts at a falling edge and lowers `sc_valid` only after a rising edge at which `sc_ready` was high. Load-linked and store-conditional tasks never overlap. Cancelling events are injected alongside load-linked or store-conditional cycles only in the scenarios that test same-cycle priority.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    SC_OK       = 2'd0,
    SC_NOLINK   = 2'd1,
    SC_MISMATCH = 2'd2,
    SC_EXPIRED  = 2'd3
  } sc_code_e;

  localparam int unsigned N_WATCH = 2;
endpackage

// File: rtl/llsc_line_match.sv
module llsc_line_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFS_W  = 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-OFS_W-1:0] tag,
  output logic                    hit
);
  assign hit = (addr[ADDR_W-1:OFS_W] == tag);
endmodule

// File: rtl/llsc_countdown.sv
module llsc_countdown #(
  parameter int unsigned PRESET = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic alive
);
  localparam int unsigned CW = $clog2(PRESET + 1);
  localparam logic [CW-1:0] START = CW'(PRESET);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= START;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign alive = (cnt_q != '0);
endmodule

// File: rtl/llsc_reserve.sv
module llsc_reserve #(
  parameter int unsigned TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             kill,
  output logic             link,
  output logic [TAG_W-1:0] tag
);
  // set wins over kill in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link <= 1'b0;
      tag  <= '0;
    end else if (set) begin
      link <= 1'b1;
      tag  <= set_tag;
    end else if (kill) begin
      link <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = 4,
  parameter int unsigned PRESET = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_valid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_valid,
  output logic              sc_ready,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [DATA_W-1:0] sc_data,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              dma_valid,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic              irq_taken
);
  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic             link;
  logic [TAG_W-1:0] tag;
  logic             alive;
  logic             sc_hit;
  logic             pass;
  logic             hold_q;
  logic             accept;
  logic             kill;
  sc_code_e         code;

  logic [N_WATCH-1:0]             ev_valid;
  logic [N_WATCH-1:0][ADDR_W-1:0] ev_addr;
  logic [N_WATCH-1:0]             ev_hit;

  assign ev_valid = {dma_valid, snoop_valid};
  assign ev_addr  = {dma_addr, snoop_addr};

  for (genvar i = 0; i < N_WATCH; i++) begin : g_watch
    llsc_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
      .addr (ev_addr[i]),
      .tag  (tag),
      .hit  (ev_hit[i])
    );
  end

  llsc_line_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_sc_match (
    .addr (sc_addr),
    .tag  (tag),
    .hit  (sc_hit)
  );

  llsc_countdown #(.PRESET(PRESET)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ll_valid),
    .alive (alive)
  );

  llsc_reserve #(.TAG_W(TAG_W)) u_resv (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (ll_valid),
    .set_tag (ll_addr[ADDR_W-1:OFS_W]),
    .kill    (kill),
    .link    (link),
    .tag     (tag)
  );

  // verdict on the state held at the start of the cycle
  always_comb begin
    if (hold_q)       code = SC_OK;
    else if (!link)   code = SC_NOLINK;
    else if (!sc_hit) code = SC_MISMATCH;
    else if (!alive)  code = SC_EXPIRED;
    else              code = SC_OK;
  end

  assign pass         = (code == SC_OK);
  assign mem_wr_valid = sc_valid && pass;
  assign mem_wr_addr  = sc_addr;
  assign mem_wr_data  = sc_data;
  assign sc_ready     = !mem_wr_valid || mem_wr_ready;
  assign accept       = sc_valid && sc_ready;
  assign kill         = irq_taken || accept || |(ev_valid & ev_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      resp_valid <= 1'b0;
      resp_code  <= 2'd0;
    end else begin
      hold_q     <= mem_wr_valid && !mem_wr_ready;
      resp_valid <= accept;
      if (accept) resp_code <= code;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ll_valid,
  input logic              sc_valid,
  input logic              sc_ready,
  input logic              resp_valid,
  input logic [1:0]        resp_code,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              irq_taken
);
  a_r10_resp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_ready) |=> resp_valid);

  a_r10_write_is_success: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && mem_wr_ready) |=> (resp_valid && resp_code == 2'd0));

  a_r11_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  a_r11_fail_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !mem_wr_valid) |-> sc_ready);

  a_r7_link_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && sc_ready && !ll_valid) |=> !mem_wr_valid);

  a_r6_irq_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_taken && !ll_valid && !mem_wr_valid) |=> !mem_wr_valid);
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ll_valid     (ll_valid),
  .sc_valid     (sc_valid),
  .sc_ready     (sc_ready),
  .resp_valid   (resp_valid),
  .resp_code    (resp_code),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .irq_taken    (irq_taken)
);

// File: tb/sim_llsc_monitor.sv
`timescale 1ns/1ps
module sim_llsc_monitor;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int OW = 4;
  localparam int PRE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ll_valid = 1'b0;
  logic [AW-1:0] ll_addr = '0;
  logic sc_valid = 1'b0;
  logic sc_ready;
  logic [AW-1:0] sc_addr = '0;
  logic [DW-1:0] sc_data = '0;
  logic resp_valid;
  logic [1:0] resp_code;
  logic mem_wr_valid;
  logic mem_wr_ready = 1'b1;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic dma_valid = 1'b0;
  logic [AW-1:0] dma_addr = '0;
  logic irq_taken = 1'b0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .OFS_W(OW), .PRESET(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .ll_valid(ll_valid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_addr(sc_addr), .sc_data(sc_data),
    .resp_valid(resp_valid), .resp_code(resp_code),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .dma_valid(dma_valid), .dma_addr(dma_addr), .irq_taken(irq_taken));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_ll(input logic [AW-1:0] a);
    ll_valid = 1'b1; ll_addr = a;
    @(negedge clk);
    ll_valid = 1'b0;
  endtask

  task automatic do_snoop(input logic [AW-1:0] a);
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic do_dma(input logic [AW-1:0] a);
    dma_valid = 1'b1; dma_addr = a;
    @(negedge clk);
    dma_valid = 1'b0;
  endtask

  task automatic do_sc(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [1:0] exp_code, input string req);
    logic exp_wr;
    exp_wr = (exp_code == 2'd0);
    sc_valid = 1'b1; sc_addr = a; sc_data = d;
    #1;
    chk(mem_wr_valid == exp_wr, req, "mem_wr_valid", 32'(mem_wr_valid), 32'(exp_wr));
    chk(sc_ready == 1'b1, req, "sc_ready", 32'(sc_ready), 32'd1);
    if (exp_wr) begin
      chk(mem_wr_addr == a, req, "mem_wr_addr", mem_wr_addr, a);
      chk(mem_wr_data == d, req, "mem_wr_data", mem_wr_data, d);
    end
    @(negedge clk);
    sc_valid = 1'b0;
    chk(resp_valid == 1'b1, req, "resp_valid", 32'(resp_valid), 32'd1);
    chk(resp_code == exp_code, req, "resp_code", 32'(resp_code), 32'(exp_code));
    #1;
    @(negedge clk);
    chk(resp_valid == 1'b0, "R10", "resp_valid one cycle", 32'(resp_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk(resp_valid == 1'b0, "R12", "resp_valid", 32'(resp_valid), 32'd0);
    chk(mem_wr_valid == 1'b0, "R12", "mem_wr_valid", 32'(mem_wr_valid), 32'd0);
    do_sc(32'h100, 32'h1, 2'd1, "R12");
  endtask

  task automatic t_basic;
    do_ll(32'h1000);
    do_sc(32'h1000, 32'hA5A5_0001, 2'd0, "R1");
    do_ll(32'h2000);
    do_sc(32'h200C, 32'hA5A5_0002, 2'd0, "R2");
    do_sc(32'h200C, 32'hA5A5_0003, 2'd1, "R7");
  endtask

  task automatic t_mismatch;
    do_ll(32'h3000);
    do_sc(32'h3010, 32'h5, 2'd2, "R8");
    do_sc(32'h3000, 32'h6, 2'd1, "R7");
  endtask

  task automatic t_timer;
    do_ll(32'h4000);
    repeat (PRE - 1) @(negedge clk);
    do_sc(32'h4000, 32'h7, 2'd0, "R3");
    do_ll(32'h4000);
    repeat (PRE) @(negedge clk);
    do_sc(32'h4000, 32'h8, 2'd3, "R3");
    do_ll(32'h4000);
    repeat (PRE) @(negedge clk);
    do_sc(32'h4040, 32'h9, 2'd2, "R10");
  endtask

  task automatic t_snoop;
    do_ll(32'h5000);
    do_snoop(32'h5010);
    do_sc(32'h5004, 32'hA, 2'd0, "R4");
    do_ll(32'h5000);
    do_snoop(32'h5008);
    do_sc(32'h5000, 32'hB, 2'd1, "R4");
  endtask

  task automatic t_dma;
    do_ll(32'h6000);
    do_dma(32'h7000);
    do_sc(32'h6000, 32'hC, 2'd0, "R5");
    do_ll(32'h6000);
    do_dma(32'h600F);
    do_sc(32'h6000, 32'hD, 2'd1, "R5");
  endtask

  task automatic t_irq;
    do_ll(32'h8000);
    irq_taken = 1'b1;
    @(negedge clk);
    irq_taken = 1'b0;
    do_sc(32'h8000, 32'hE, 2'd1, "R6");
    do_sc(32'h9990, 32'hE, 2'd1, "R10");
  endtask

  task automatic t_priority;
    irq_taken = 1'b1; snoop_valid = 1'b1; snoop_addr = 32'hA000;
    do_ll(32'hA000);
    irq_taken = 1'b0; snoop_valid = 1'b0;
    do_sc(32'hA000, 32'hF, 2'd0, "R9");
    do_ll(32'hA000);
    do_ll(32'hB000);
    do_sc(32'hA000, 32'h10, 2'd2, "R9");
    do_ll(32'hC000);
    repeat (PRE - 2) @(negedge clk);
    do_ll(32'hC000);
    repeat (PRE - 1) @(negedge clk);
    do_sc(32'hC000, 32'h11, 2'd0, "R9");
  endtask

  task automatic t_same_cycle;
    do_ll(32'hD000);
    irq_taken = 1'b1; dma_valid = 1'b1; dma_addr = 32'hD000;
    do_sc(32'hD000, 32'h12, 2'd0, "R13");
    irq_taken = 1'b0; dma_valid = 1'b0;
  endtask

  task automatic t_stall;
    do_ll(32'hE000);
    mem_wr_ready = 1'b0;
    sc_valid = 1'b1; sc_addr = 32'hE008; sc_data = 32'h1234_5678;
    for (int i = 0; i < 3; i++) begin
      irq_taken = (i == 1);
      #1;
      chk(mem_wr_valid == 1'b1, "R11", "stall valid", 32'(mem_wr_valid), 32'd1);
      chk(sc_ready == 1'b0, "R11", "stall ready", 32'(sc_ready), 32'd0);
      chk(mem_wr_addr == 32'hE008, "R11", "stall addr", mem_wr_addr, 32'hE008);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R11", "no resp in stall", 32'(resp_valid), 32'd0);
    end
    irq_taken = 1'b0;
    mem_wr_ready = 1'b1;
    #1;
    chk(sc_ready == 1'b1, "R11", "ready follows mem", 32'(sc_ready), 32'd1);
    chk(mem_wr_data == 32'h1234_5678, "R11", "stall data", mem_wr_data, 32'h1234_5678);
    @(negedge clk);
    sc_valid = 1'b0;
    chk(resp_valid && resp_code == 2'd0, "R11", "stall resp", 32'(resp_code), 32'd0);
    mem_wr_ready = 1'b0;
    do_sc(32'hE000, 32'h13, 2'd1, "R11");
    mem_wr_ready = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_mismatch;
    t_timer;
    t_snoop;
    t_dma;
    t_irq;
    t_priority;
    t_same_cycle;
    t_stall;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule